// File: doc/BRIEF.md
# Read-Path Parity Error Injector

This block sits in the read-return path between a DRAM interface and a memory-controller core. Read data arrives as cachelines of eight 64-bit beats. Each beat carries two parity bits, so a line carries sixteen. A 32-bit control register holds a sixteen-bit flip mask, a flip-enable bit and a poison-enable bit. While flip-enable is set, the mask is XORed into the parity bits of every cacheline, beat by beat. This lets firmware plant parity faults in a chosen lane of a chosen beat.

After the optional flip, every beat is checked against the even parity of its data.

- With poison-enable set, a beat that fails the check keeps its faulty parity and leaves with a poison flag.
- With poison-enable clear, the block replaces the parity with freshly computed clean parity and never raises the flag.

The control settings are captured once per cacheline, on its first beat. A register write made in the middle of a line therefore takes effect only from the next line.

Both streams use valid/ready handshakes with one output register stage. A beat is accepted when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. An output beat stays on the port, unchanged, until `out_ready` takes it. The control register port is plain: a write strobe with data, and a continuous readback.

Top module: `rd_parity_injector`

## Requirements
- R1: After reset the control readback is zero, `out_valid` is low and `in_ready` is high, so both injection and poisoning start disabled.
- R2: A control write stores mask bits 15:0, flip-enable at bit 17 and poison-enable at bit 18. Bit 16 and bits 31:19 always read back as zero, so writing all ones reads back 0x0006FFFF.
- R3: `in_ready` is high when the output stage is empty or `out_ready` is high. An accepted beat is presented one cycle later. While `out_valid` is high and `out_ready` is low, the output beat and its flags hold steady.
- R4: Data passes through unchanged and in order. The beat index counts accepted beats from 0 (the first beat of a line) to 7 and wraps to 0.
- R5: With flip-enable set, the parity of beat n is XORed with mask bits 2n+1:2n. Parity bit 0 of a beat goes with data bits 31:0 and bit 1 goes with data bits 63:32. The mask is applied on every cacheline, not just once.
- R6: With flip-enable clear, the mask has no effect on the parity or on the poison flag.
- R7: Parity is even: a lane is correct when its bit equals the XOR of its 32 data bits. With poison-enable set, `out_par` is the received parity after any flip, and `out_poison` is high in the same cycle as the beat exactly when a lane fails. This includes faults present on the input itself.
- R8: With poison-enable clear, `out_par` is always the recomputed clean even parity and `out_poison` stays low, even for beats that arrive with bad parity.
- R9: The settings in use for a cacheline are sampled when its beat 0 is accepted. A write made while beats 1 to 7 are in flight changes nothing until the next beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be accepted |
| in_data | input | 64 | Input beat data |
| in_par | input | 2 | Input beat parity (bit 0 for data 31:0, bit 1 for data 63:32) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 64 | Output beat data |
| out_par | output | 2 | Output beat parity |
| out_poison | output | 1 | Output beat flagged as poisoned |

## Verification
A beat counter that slips shows up on the very next beat: the mask slice lands on the wrong beat, and the output parity or poison flag differs from the scoreboard. Latched settings that are stale or too fresh show up on the first beat after a mid-line write. An injected fault then appears one line early or late.

A broken hold register shows up within one stalled cycle as a changed or duplicated output beat. Random back-pressure keeps stalls frequent throughout the run.

// File: rtl/rdinj_pkg.sv
package rdinj_pkg;
  localparam int BEAT_W       = 64;
  localparam int PAR_PER_BEAT = 2;
  localparam int BEATS        = 8;
  localparam int LANE_W       = BEAT_W / PAR_PER_BEAT;
  localparam int MASK_W       = PAR_PER_BEAT * BEATS;
  localparam int IDX_W        = $clog2(BEATS);
  localparam int CFG_W        = 32;
  localparam int FLIP_BIT     = 17;
  localparam int POISON_BIT   = 18;
  localparam logic [CFG_W-1:0] CFG_WMASK =
    (CFG_W'(1) << POISON_BIT) | (CFG_W'(1) << FLIP_BIT) | ((CFG_W'(1) << MASK_W) - CFG_W'(1));

  typedef struct packed {
    logic              poison_en;
    logic              flip_en;
    logic [MASK_W-1:0] mask;
  } inj_cfg_t;

  function automatic logic [PAR_PER_BEAT-1:0] even_par(input logic [BEAT_W-1:0] d);
    logic [PAR_PER_BEAT-1:0] p;
    for (int i = 0; i < PAR_PER_BEAT; i++) p[i] = ^d[i*LANE_W +: LANE_W];
    return p;
  endfunction
endpackage

// File: rtl/rdinj_cfg_reg.sv
module rdinj_cfg_reg
  import rdinj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output inj_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) begin
      cfg.mask      <= wdata[MASK_W-1:0];
      cfg.flip_en   <= wdata[FLIP_BIT];
      cfg.poison_en <= wdata[POISON_BIT];
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[MASK_W-1:0] = cfg.mask;
    rdata[FLIP_BIT]   = cfg.flip_en;
    rdata[POISON_BIT] = cfg.poison_en;
  end
endmodule

// File: rtl/rdinj_beat_track.sv
module rdinj_beat_track
  import rdinj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  inj_cfg_t         live_cfg,
  output logic [IDX_W-1:0] beat_idx,
  output inj_cfg_t         act_cfg
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] cnt_q;
  inj_cfg_t         held_q;
  logic             line_start;

  assign line_start = (cnt_q == '0);
  assign beat_idx   = cnt_q;
  assign act_cfg    = line_start ? live_cfg : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + IDX_W'(1);
      if (line_start) held_q <= live_cfg;
    end
  end
endmodule

// File: rtl/rdinj_par_lane.sv
module rdinj_par_lane
  import rdinj_pkg::*;
(
  input  logic [BEAT_W-1:0]       data,
  input  logic [PAR_PER_BEAT-1:0] par_in,
  input  logic [PAR_PER_BEAT-1:0] flip,
  input  logic                    poison_en,
  output logic [PAR_PER_BEAT-1:0] par_out,
  output logic                    poison
);
  logic [PAR_PER_BEAT-1:0] flipped, fresh, bad;

  for (genvar g = 0; g < PAR_PER_BEAT; g++) begin : g_lane
    assign flipped[g] = par_in[g] ^ flip[g];
    assign fresh[g]   = ^data[g*LANE_W +: LANE_W];
    assign bad[g]     = flipped[g] ^ fresh[g];
  end

  assign par_out = poison_en ? flipped : fresh;
  assign poison  = poison_en & (|bad);
endmodule

// File: rtl/rd_parity_injector.sv
module rd_parity_injector
  import rdinj_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic [CFG_W-1:0]        cfg_rdata,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BEAT_W-1:0]       in_data,
  input  logic [PAR_PER_BEAT-1:0] in_par,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BEAT_W-1:0]       out_data,
  output logic [PAR_PER_BEAT-1:0] out_par,
  output logic                    out_poison
);
  inj_cfg_t                live_cfg, act_cfg;
  logic [IDX_W-1:0]        beat_idx;
  logic                    accept;
  logic [PAR_PER_BEAT-1:0] flip, par_nxt;
  logic                    poison_nxt;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rdinj_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(live_cfg), .rdata(cfg_rdata)
  );

  rdinj_beat_track u_track (
    .clk(clk), .rst_n(rst_n), .adv(accept), .live_cfg(live_cfg),
    .beat_idx(beat_idx), .act_cfg(act_cfg)
  );

  assign flip = act_cfg.flip_en ? act_cfg.mask[beat_idx*PAR_PER_BEAT +: PAR_PER_BEAT] : '0;

  rdinj_par_lane u_lane (
    .data(in_data), .par_in(in_par), .flip(flip), .poison_en(act_cfg.poison_en),
    .par_out(par_nxt), .poison(poison_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_par    <= '0;
      out_poison <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data   <= in_data;
        out_par    <= par_nxt;
        out_poison <= poison_nxt;
      end
    end
  end
endmodule

// File: rtl/rd_parity_injector_chk.sv
module rd_parity_injector_chk
  import rdinj_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [CFG_W-1:0]        cfg_wdata,
  input logic [CFG_W-1:0]        cfg_rdata,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [BEAT_W-1:0]       out_data,
  input logic [PAR_PER_BEAT-1:0] out_par,
  input logic                    out_poison
);
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_WMASK)); // R2
  AST_ACCEPT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_par) && $stable(out_poison)); // R3
  AST_POISON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_poison |-> out_par != even_par(out_data)); // R7
  AST_CLEAN_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_poison |-> out_par == even_par(out_data)); // R8
endmodule

bind rd_parity_injector rd_parity_injector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_par(out_par), .out_poison(out_poison)
);

// File: tb/rd_parity_injector_tb.sv
`timescale 1ns/1ps
module rd_parity_injector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_par = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [1:0]  out_par;
  logic        out_poison;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit bp_en = 1'b0;

  logic [63:0] q_data[$];
  logic [1:0]  q_par[$];
  logic        q_pois[$];
  string       q_tag[$];

  logic [15:0] m_mask = '0;
  logic        m_fe = 1'b0, m_pe = 1'b0;
  logic [15:0] a_mask = '0;
  logic        a_fe = 1'b0, a_pe = 1'b0;
  int          m_idx = 0;

  always #2.5 clk = ~clk;

  rd_parity_injector u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_par(in_par),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_par(out_par),
    .out_poison(out_poison)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] good_par(input logic [63:0] d);
    return {^d[63:32], ^d[31:0]};
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_mask = v[15:0];
    m_fe = v[17];
    m_pe = v[18];
  endtask

  task automatic send_beat(input logic [63:0] d, input logic [1:0] p, input string tag);
    logic [1:0] fp, cp, err;
    in_valid = 1'b1;
    in_data = d;
    in_par = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (m_idx == 0) begin
      a_mask = m_mask; a_fe = m_fe; a_pe = m_pe;
    end
    fp = p ^ (a_fe ? a_mask[2*m_idx +: 2] : 2'b00);
    cp = good_par(d);
    err = fp ^ cp;
    q_data.push_back(d);
    q_par.push_back(a_pe ? fp : cp);
    q_pois.push_back(a_pe & (|err));
    q_tag.push_back(tag);
    m_idx = (m_idx + 1) % 8;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_line(input bit bad_native, input string tag);
    for (int b = 0; b < 8; b++) begin
      logic [63:0] d;
      logic [1:0] p;
      d = {$urandom, $urandom};
      p = good_par(d);
      if (bad_native && (b % 3 == 1)) p = p ^ 2'(b & 3);
      send_beat(d, p, tag);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R3 unexpected beat", 64'(out_data), 64'd0);
      end else begin
        logic [63:0] ed;
        logic [1:0]  ep;
        logic        epo;
        string       t;
        ed = q_data.pop_front();
        ep = q_par.pop_front();
        epo = q_pois.pop_front();
        t = q_tag.pop_front();
        chk(out_data === ed, "R4 data", out_data, ed);
        chk(out_par === ep, {t, " parity"}, 64'(out_par), 64'(ep));
        chk(out_poison === epo, {t, " poison"}, 64'(out_poison), 64'(epo));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 32'h0, "R1 cfg", 64'(cfg_rdata), 64'h0);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register layout
    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0006_FFFF, "R2 all ones", 64'(cfg_rdata), 64'h0006_FFFF);
    write_cfg(32'h0001_1234);
    chk(cfg_rdata == 32'h0000_1234, "R2 bit16 dropped", 64'(cfg_rdata), 64'h1234);

    // R4 passthrough, injection off
    write_cfg(32'h0);
    send_line(1'b0, "R4");
    send_line(1'b0, "R4");

    // R8 flip on, poison off: clean parity regenerated
    write_cfg(32'h0002_A5C3);
    send_line(1'b0, "R8");
    send_line(1'b1, "R8");

    // R5 R7 flip and poison on, single lanes per beat
    write_cfg(32'h0006_0001);
    send_line(1'b0, "R5");
    write_cfg(32'h0006_8000);
    send_line(1'b0, "R5");
    write_cfg(32'h0006_9C36);
    send_line(1'b0, "R7");
    send_line(1'b0, "R5 repeat");

    // R6 mask ignored when flip off; R7 native faults detected
    write_cfg(32'h0004_FFFF);
    send_line(1'b0, "R6");
    send_line(1'b1, "R7 native");

    // R9 mid-line write
    write_cfg(32'h0006_0000);
    for (int b = 0; b < 3; b++) send_beat({$urandom, $urandom} & 64'hFFFF_FFFF_0000_0000, 2'b00, "R9 old");
    write_cfg(32'h0006_FFFF);
    for (int b = 0; b < 5; b++) send_beat(64'h0, 2'b00, "R9 old");
    send_line(1'b0, "R9 new");

    // random traffic with back-pressure, counter wraps (R3 R4)
    bp_en = 1'b1;
    for (int l = 0; l < 40; l++) begin
      write_cfg($urandom);
      send_beat({$urandom, $urandom}, 2'($urandom), "R3 rand");
      if (l % 4 == 0) write_cfg($urandom);
      for (int b = 1; b < 8; b++) send_beat({$urandom, $urandom}, 2'($urandom), "R3 rand");
    end

    bp_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(q_data.size() == 0, "R3 drained", 64'(q_data.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule